// File: doc/BRIEF.md
# Timer Status Flag Register

This block holds the sticky event flags of a six-channel capture/compare timer. The timer core gives it one-cycle pulses: a counter update, capture/compare events on channels 1 to 4, compare events on channels 5 and 6, commutation and trigger. It also receives two break inputs, each a level signal. Each event sets its own flag. Channels 1 to 4 also carry an overcapture flag. That flag records a capture that arrived while the channel's previous capture flag was still pending.

Software reads the flags through a small synchronous register port. It clears a flag by writing 0 to that bit, and writing 1 leaves the bit as it is. A second register holds the interrupt enables. The block ANDs the flags with those enables, ORs the results, and drives a registered interrupt request line.

Top module: `tmr_flag_reg`

## Requirements
- R1: After reset the status word, the enable word and `irq` are all zero.
- R2: The status word is 32 bits. Bits 31:18 and 15:13 always read as 0. In the enable word, only bits 7:0, 16 and 17 hold a value, and every other bit reads as 0.
- R3: The status bit positions are as follows. Bit 0 is update. Bits 1 to 4 are capture/compare channels 1 to 4. Bit 5 is commutation and bit 6 is trigger. Bit 7 is break and bit 8 is the second break. Bits 9 to 12 are overcapture for channels 1 to 4. Bit 16 is compare channel 5 and bit 17 is compare channel 6. An event pulse sampled at a clock edge sets its bit at that edge.
- R4: A write to the status address (word address 1) clears every bit whose write-data bit is 0. Bits written with 1 are left unchanged. A flag never sets without an event.
- R5: When an event and a clear-by-zero reach the same bit in one cycle, the bit ends up set.
- R6: Each overcapture flag for channels 1 to 4 sets only in one case. A capture event must arrive while that channel's capture-mode input is 1 and its capture/compare flag is already set. Channels 5 and 6 never set bits 13 to 15.
- R7: Each break flag sets on the cycle its input goes from inactive to active, and an input already active when reset is released also sets it. While that input is still active, a clear-by-zero of the flag is refused. Once the input is inactive, the same clear takes effect.
- R8: One clock edge after the flags and enables change, `irq` becomes the OR of flag AND enable. Enable bits 0 to 6 and 16 to 17 gate the flags at the same positions. Enable bit 7 gates both break flags. The overcapture flags never raise `irq`.
- R9: The enable word lives at word address 0. A write stores its writable bits, and a read returns them.
- R10: A read never changes any flag. A write to any other address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| ev_update | input | 1 | Counter update event pulse |
| ev_cc | input | 4 | Capture/compare event pulses, channels 1 to 4 |
| cap_mode | input | 4 | Channel 1 to 4 is configured for input capture |
| ev_cmp | input | 2 | Compare event pulses, channels 5 and 6 |
| ev_com | input | 1 | Commutation event pulse |
| ev_trig | input | 1 | Trigger event pulse |
| brk_in | input | 1 | Break input level, 1 = active |
| brk2_in | input | 1 | Second break input level, 1 = active |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench targets the cycle where a hardware event and a software clear hit the same bit. A design where the clear won there would lose the event and read back 0. It repeats captures on a channel whose flag is still set, once in capture mode and once in compare mode, and also on channels 5 and 6. A design that ignored the mode, or that gave the compare-only channels overcapture bits, would show a stray bit 9 to 15. It clears a break flag once with its input held active and once with the input released. It checks that writing 1 is harmless and that enable bit 7 alone gates the second break. It also checks that overcapture alone keeps `irq` low. These catch a design that inverts the clear sense, lets a clear through during an active break, or wires overcapture into the interrupt.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
   localparam int SR_W     = 32;
   localparam int BIT_UPD  = 0;
   localparam int BIT_CC0  = 1;
   localparam int N_CC     = 4;
   localparam int BIT_COM  = 5;
   localparam int BIT_TRG  = 6;
   localparam int BIT_BRK  = 7;
   localparam int BIT_BRK2 = 8;
   localparam int BIT_OVR0 = 9;
   localparam int BIT_CMP0 = 16;
   localparam int N_CMP    = 2;
   // bits that hold a flag; the rest read zero
   localparam logic [SR_W-1:0] SR_USED  = 32'h0003_1FFF;
   // writable enable bits
   localparam logic [SR_W-1:0] IER_USED = 32'h0003_00FF;
endpackage

// File: rtl/tsf_flag_cell.sv
module tsf_flag_cell #(
   parameter bit HOLD = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic hold_i,
   output logic flag_o
);
   localparam logic HOLD_EN = HOLD;

   logic clr_eff;
   assign clr_eff = clr_i & ~(hold_i & HOLD_EN);

   always_ff @(posedge clk) begin
      if (!rst_n)      flag_o <= 1'b0;
      else if (set_i)  flag_o <= 1'b1;
      else if (clr_eff) flag_o <= 1'b0;
   end

   p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_o && !set_i) |=> !flag_o);
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && clr_i && !set_i && !hold_i) |=> !flag_o);

   generate
      if (HOLD) begin : g_hold
         p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o && hold_i) |=> flag_o);
      end
   endgenerate
endmodule

// File: rtl/tsf_irq_gate.sv
module tsf_irq_gate #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] flags_i,
   input  logic [W-1:0] en_i,
   output logic         irq_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("tsf_irq_gate: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |(flags_i & en_i);
   end

   p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flags_i & en_i)) |=> irq_o);
   p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(flags_i & en_i)) |=> !irq_o);
endmodule

// File: rtl/tmr_flag_reg.sv
module tmr_flag_reg
   import tsf_pkg::*;
#(
   parameter int          ADDR_W   = 4,
   parameter int unsigned IER_ADDR = 0,
   parameter int unsigned SR_ADDR  = 1,
   parameter bit          BRK_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [SR_W-1:0]   bus_wdata,
   output logic [SR_W-1:0]   bus_rdata,
   input  logic              ev_update,
   input  logic [N_CC-1:0]   ev_cc,
   input  logic [N_CC-1:0]   cap_mode,
   input  logic [N_CMP-1:0]  ev_cmp,
   input  logic              ev_com,
   input  logic              ev_trig,
   input  logic              brk_in,
   input  logic              brk2_in,
   output logic              irq
);
   localparam int unsigned N_ADDR = 1 << ADDR_W;

   generate
      if (ADDR_W < 1) begin : g_bad_aw
         $error("tmr_flag_reg: ADDR_W must be at least 1");
      end
      if (IER_ADDR == SR_ADDR) begin : g_bad_map
         $error("tmr_flag_reg: register addresses collide");
      end
      if (IER_ADDR >= N_ADDR || SR_ADDR >= N_ADDR) begin : g_bad_range
         $error("tmr_flag_reg: register address out of range");
      end
   endgenerate

   logic [SR_W-1:0] flags, set_vec, hold_vec, ier_q, en_vec;
   logic [1:0]      brk_prev;
   logic            sr_wr, ier_wr;

   assign sr_wr  = bus_we && (bus_addr == ADDR_W'(SR_ADDR));
   assign ier_wr = bus_we && (bus_addr == ADDR_W'(IER_ADDR));

   always_ff @(posedge clk) begin
      if (!rst_n) brk_prev <= 2'b00;
      else        brk_prev <= {brk2_in, brk_in};
   end

   always_comb begin
      set_vec = '0;
      set_vec[BIT_UPD] = ev_update;
      for (int i = 0; i < N_CC; i++) begin
         set_vec[BIT_CC0+i]  = ev_cc[i];
         set_vec[BIT_OVR0+i] = ev_cc[i] & cap_mode[i] & flags[BIT_CC0+i];
      end
      set_vec[BIT_COM]  = ev_com;
      set_vec[BIT_TRG]  = ev_trig;
      set_vec[BIT_BRK]  = brk_in  & ~brk_prev[0];
      set_vec[BIT_BRK2] = brk2_in & ~brk_prev[1];
      for (int j = 0; j < N_CMP; j++) set_vec[BIT_CMP0+j] = ev_cmp[j];
   end

   always_comb begin
      hold_vec = '0;
      hold_vec[BIT_BRK]  = brk_in;
      hold_vec[BIT_BRK2] = brk2_in;
   end

   generate
      for (genvar b = 0; b < SR_W; b++) begin : g_bit
         if (SR_USED[b]) begin : g_flag
            tsf_flag_cell #(
               .HOLD(BRK_HOLD && (b == BIT_BRK || b == BIT_BRK2))
            ) u_cell (
               .clk   (clk),
               .rst_n (rst_n),
               .set_i (set_vec[b]),
               .clr_i (sr_wr & ~bus_wdata[b]),
               .hold_i(hold_vec[b]),
               .flag_o(flags[b])
            );
         end else begin : g_rsvd
            assign flags[b] = 1'b0;
         end
      end
   endgenerate

   logic unused_bits;
   assign unused_bits = ^{set_vec & ~SR_USED, hold_vec & ~SR_USED};

   always_ff @(posedge clk) begin
      if (!rst_n)      ier_q <= '0;
      else if (ier_wr) ier_q <= bus_wdata & IER_USED;
   end

   always_comb begin
      en_vec = '0;
      en_vec[BIT_TRG:BIT_UPD] = ier_q[BIT_TRG:BIT_UPD];
      en_vec[BIT_BRK]  = ier_q[BIT_BRK];
      en_vec[BIT_BRK2] = ier_q[BIT_BRK];
      for (int j = 0; j < N_CMP; j++) en_vec[BIT_CMP0+j] = ier_q[BIT_CMP0+j];
   end

   always_comb begin
      if (bus_addr == ADDR_W'(SR_ADDR))       bus_rdata = flags;
      else if (bus_addr == ADDR_W'(IER_ADDR)) bus_rdata = ier_q;
      else                                    bus_rdata = '0;
   end

   tsf_irq_gate #(.W(SR_W)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .flags_i(flags),
      .en_i   (en_vec),
      .irq_o  (irq)
   );

   p_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(SR_ADDR)) |-> ((bus_rdata & ~SR_USED) == '0));
   p_ier_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(IER_ADDR)) |-> ((bus_rdata & ~IER_USED) == '0));

   generate
      for (genvar c = 0; c < N_CC; c++) begin : g_ovr_chk
         p_ovr_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[BIT_OVR0+c]) |->
               $past(ev_cc[c] && cap_mode[c] && flags[BIT_CC0+c]));
      end
   endgenerate
endmodule

// File: tb/tmr_flag_reg_tb.sv
module tmr_flag_reg_tb;
   localparam int AW = 4;
   localparam logic [AW-1:0] A_IER = 4'd0;
   localparam logic [AW-1:0] A_SR  = 4'd1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          ev_update = 1'b0, ev_com = 1'b0, ev_trig = 1'b0;
   logic [3:0]    ev_cc = '0, cap_mode = '0;
   logic [1:0]    ev_cmp = '0;
   logic          brk_in = 1'b0, brk2_in = 1'b0;
   logic          irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tmr_flag_reg #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_update(ev_update),
      .ev_cc(ev_cc), .cap_mode(cap_mode), .ev_cmp(ev_cmp), .ev_com(ev_com),
      .ev_trig(ev_trig), .brk_in(brk_in), .brk2_in(brk2_in), .irq(irq)
   );

   // scoreboard: kind 0 = read data, 1 = irq level
   logic [31:0] exp_q[$];
   bit          kind_q[$];
   string       tag_q[$];

   logic [31:0] m_exp, m_act;
   bit          m_kind;
   string       m_tag;

   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         m_exp  = exp_q.pop_front();
         m_kind = kind_q.pop_front();
         m_tag  = tag_q.pop_front();
         m_act  = m_kind ? {31'd0, irq} : bus_rdata;
         checks++;
         if (m_act !== m_exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", m_tag, m_act, m_exp);
         end
      end
   end

   task automatic go();
      @(posedge clk);
      #1;
      bus_we = 1'b0; ev_update = 1'b0; ev_cc = '0; ev_cmp = '0;
      ev_com = 1'b0; ev_trig = 1'b0;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
      bus_addr = a;
      exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
   endtask

   task automatic chk_irq(input logic e, input string t);
      exp_q.push_back({31'd0, e}); kind_q.push_back(1'b1); tag_q.push_back(t);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      go(); rd(A_SR, 32'h0, "R1 status after reset");
      go(); rd(A_IER, 32'h0, "R1 enable after reset"); chk_irq(1'b0, "R1 irq after reset");

      // R3 bit positions
      go(); ev_update = 1'b1;
      go(); rd(A_SR, 32'h0000_0001, "R3 update bit");
      go(); ev_cc = 4'hF; ev_cmp = 2'b11; ev_com = 1'b1; ev_trig = 1'b1;
      go(); rd(A_SR, 32'h0003_007F, "R3 all event bits");

      // R4 write-one keeps, write-zero clears
      go(); wr(A_SR, 32'hFFFF_FFFF);
      go(); rd(A_SR, 32'h0003_007F, "R4 write ones no change");
      go(); wr(A_SR, ~32'h1);
      go(); rd(A_SR, 32'h0003_007E, "R4 clear update only");

      // R5 set wins over clear
      go(); wr(A_SR, 32'h0); ev_trig = 1'b1;
      go(); rd(A_SR, 32'h0000_0040, "R5 set beats clear");

      // R6 overcapture
      cap_mode = 4'b0001;
      go(); ev_cc = 4'b0001;
      go(); rd(A_SR, 32'h0000_0042, "R6 first capture no overcapture");
      go(); ev_cc = 4'b0001;
      go(); rd(A_SR, 32'h0000_0242, "R6 overcapture ch1");
      go(); ev_cc = 4'b0010;
      go(); ev_cc = 4'b0010;
      go(); rd(A_SR, 32'h0000_0246, "R6 compare mode no overcapture");
      go(); ev_cmp = 2'b11;
      go(); ev_cmp = 2'b11;
      go(); rd(A_SR, 32'h0003_0246, "R6 ch5 ch6 no overcapture");
      go(); wr(A_SR, 32'h0);
      go(); rd(A_SR, 32'h0, "R4 clear all");

      // R9 and R2 enable register
      go(); wr(A_IER, 32'hFFFF_FFFF);
      go(); rd(A_IER, 32'h0003_00FF, "R9 R2 enable writable bits");
      go(); wr(A_IER, 32'h0);
      go(); rd(A_IER, 32'h0, "R9 enable cleared");

      // R7 break hold
      go(); brk_in = 1'b1;
      go(); rd(A_SR, 32'h0000_0080, "R7 break set on activation");
      go(); wr(A_SR, 32'h0);
      go(); rd(A_SR, 32'h0000_0080, "R7 clear refused while active");
      go(); brk_in = 1'b0;
      go(); wr(A_SR, 32'h0);
      go(); rd(A_SR, 32'h0, "R7 clear after release");
      go(); brk2_in = 1'b1;
      go(); rd(A_SR, 32'h0000_0100, "R7 break2 set");
      go(); wr(A_SR, 32'h0);
      go(); rd(A_SR, 32'h0000_0100, "R7 break2 clear refused");
      go(); brk2_in = 1'b0;
      go(); wr(A_SR, 32'h0);
      go(); rd(A_SR, 32'h0, "R7 break2 cleared");

      // R8 interrupt
      go(); ev_update = 1'b1;
      go();
      go(); chk_irq(1'b0, "R8 disabled flag no irq");
      go(); wr(A_IER, 32'h1);
      go();
      go(); chk_irq(1'b1, "R8 update enabled irq");
      go(); wr(A_SR, 32'h0);
      go();
      go(); chk_irq(1'b0, "R8 irq drops after clear");
      go(); wr(A_IER, 32'h0003_00FF);
      go(); ev_cc = 4'b0001;
      go(); ev_cc = 4'b0001;
      go(); wr(A_SR, ~32'h2);
      go(); rd(A_SR, 32'h0000_0200, "R8 overcapture left alone");
      go(); chk_irq(1'b0, "R8 overcapture no irq");
      go(); wr(A_SR, 32'h0);
      go(); wr(A_IER, 32'h80);
      go(); brk2_in = 1'b1;
      go();
      go(); chk_irq(1'b1, "R8 break2 gated by bit7");
      go(); wr(A_IER, 32'h1);
      go();
      go(); chk_irq(1'b0, "R8 break2 masked without bit7");

      // R10 other address and reads
      brk2_in = 1'b0;
      go(); wr(A_SR, 32'h0);
      go(); ev_update = 1'b1;
      go(); wr(4'd2, 32'h0);
      go(); rd(A_SR, 32'h1, "R10 other address no clear");
      go(); rd(A_SR, 32'h1, "R10 read does not clear");
      go(); rd(A_IER, 32'h1, "R10 enable unchanged");
      go(); rd(4'd2, 32'h0, "R10 unmapped reads zero");

      go(); go();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule